// File: doc/BRIEF.md
# Dual-Pair Lockstep Supervisor

This controller watches four processor cores that run in lockstep as two pairs, A and B. Each pair has its own comparator, and the controller receives one mismatch flag per pair. While neither pair disagrees, pair A drives the system outputs. When exactly one pair reports a disagreement, that pair is halted and the output selector moves to the other pair in the same cycle, so the system keeps running on the healthy pair.

Recovery is deferred. The controller waits until a permission input says a reconfiguration window is open. It then strobes a reconfiguration request toward the healthy side and waits for a done handshake. Next it strobes a resynchronisation request and waits for a second done handshake. After that it returns to four-core lockstep. Each handshake is guarded by a cycle-count limit supplied on an input port. A reboot request is raised if both pairs disagree together, if the healthy pair disagrees during recovery, or if a handshake limit runs out. After a reboot request the controller stays in the reboot state until reset.

States:
- `ST_FULL`: four-way lockstep.
- `ST_RUN_A`: one-cycle degraded state, B is faulty.
- `ST_RUN_B`: one-cycle degraded state, A is faulty.
- `ST_WAIT`: waiting for the reconfiguration window.
- `ST_RECFG`: reconfiguration in progress.
- `ST_RESYNC`: resynchronisation in progress.
- `ST_REBOOT`: reboot requested.

Transitions:
- `ST_FULL` to `ST_RUN_A` when only B mismatches.
- `ST_FULL` to `ST_RUN_B` when only A mismatches.
- `ST_FULL` to `ST_REBOOT` when both mismatch.
- `ST_RUN_x` to `ST_WAIT` unconditionally, or to `ST_REBOOT` if the running pair mismatches.
- `ST_WAIT` to `ST_RECFG` when the window is open.
- `ST_RECFG` to `ST_RESYNC` on reconfiguration done.
- `ST_RESYNC` to `ST_FULL` on resync done.
- Any recovery state to `ST_REBOOT` on a healthy-pair mismatch or a handshake timeout.
- `ST_REBOOT` holds until reset.

Top module: `lockstep_pair_supervisor`

## Requirements
- R1: After reset the block is in four-way lockstep: both halts low, `out_sel_b` low (pair A selected), and all three request strobes low.
- R2: In four-way lockstep with no mismatch, the window, done and flag inputs have no effect: no halt, no strobe, and `out_sel_b` stays 0.
- R3: In four-way lockstep, a mismatch on exactly one pair raises that pair's halt in the same cycle. In that cycle `out_sel_b` is set to the other pair (1 = pair B drives, 0 = pair A drives). This holds in every later cycle until lockstep resumes.
- R4: A mismatch on both pairs in the same lockstep cycle raises `reboot_req` in that cycle, with both halts high and `out_sel_b` 0. From the next cycle until reset, both halts stay high, `out_sel_b` is 0 and no strobe occurs.
- R5: Once a pair is halted, its own mismatch flag is ignored until lockstep resumes.
- R6: `recfg_req` is never raised in the detection cycle or the following degraded cycle. It is raised for one cycle in the first cycle from the second cycle after detection onward in which `recfg_window` is 1.
- R7: `resync_req` is raised for one cycle in the cycle where `recfg_done` is seen during reconfiguration. `recfg_done` has no effect in any other state.
- R8: `resync_done` seen during resynchronisation returns the block to lockstep in the next cycle: halts low and `out_sel_b` 0.
- R9: A mismatch on the healthy pair in the degraded, waiting, reconfiguration or resync state raises `reboot_req` in that cycle.
- R10: With limit L on `hs_timeout`, each handshake is accepted in any of the first L+1 cycles spent in its state. If the handshake is absent through the (L+1)-th cycle, `reboot_req` is raised in that cycle.
- R11: Each request strobe lasts one cycle, and at most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mism_a | input | 1 | Pair A internal comparator mismatch |
| mism_b | input | 1 | Pair B internal comparator mismatch |
| recfg_window | input | 1 | Reconfiguration is currently permitted |
| recfg_done | input | 1 | Reconfiguration of faulty side finished |
| resync_done | input | 1 | Resynchronisation finished |
| hs_timeout | input | TMO_W | Handshake limit L in cycles |
| halt_a | output | 1 | Halt pair A |
| halt_b | output | 1 | Halt pair B |
| out_sel_b | output | 1 | 1 = pair B drives system outputs |
| recfg_req | output | 1 | Strobe: healthy side to reconfigure faulty side |
| resync_req | output | 1 | Strobe: align recovered pair |
| reboot_req | output | 1 | Strobe: full system reboot |

## Verification
Every halt, select and strobe result is a same-cycle function of the current state and the inputs. Mismatch, window and done inputs therefore show their effect in the very cycle they are driven, while the state they cause shows up one cycle later. The handshake limit is checked both one cycle inside and exactly at its edge. The bench drives inputs on the falling edge and pushes the expected outputs for that same cycle into a queue. A monitor then pops and compares them a quarter period later, before the next rising edge registers the state.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [2:0] {
        ST_FULL   = 3'd0,
        ST_RUN_A  = 3'd1,
        ST_RUN_B  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_RECFG  = 3'd4,
        ST_RESYNC = 3'd5,
        ST_REBOOT = 3'd6
    } lps_state_e;

endpackage

// File: rtl/lps_hs_timer.sv
module lps_hs_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == limit);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(limit)) |-> (cnt_q <= limit)); // R10

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mism_a,
    input  logic       mism_b,
    input  logic       recfg_window,
    input  logic       recfg_done,
    input  logic       resync_done,
    input  logic       expired,
    output lps_state_e state_q,
    output lps_state_e state_d,
    output logic       bad_b_q
);

    logic healthy_mism;
    logic bad_b_d;

    assign healthy_mism = bad_b_q ? mism_a : mism_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            bad_b_q <= 1'b0;
        end else begin
            state_q <= state_d;
            bad_b_q <= bad_b_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bad_b_d = bad_b_q;
        unique case (state_q)
            ST_FULL: begin
                if (mism_a && mism_b) begin
                    state_d = ST_REBOOT;
                end else if (mism_b) begin
                    state_d = ST_RUN_A;
                    bad_b_d = 1'b1;
                end else if (mism_a) begin
                    state_d = ST_RUN_B;
                    bad_b_d = 1'b0;
                end
            end
            ST_RUN_A:  state_d = mism_a ? ST_REBOOT : ST_WAIT;
            ST_RUN_B:  state_d = mism_b ? ST_REBOOT : ST_WAIT;
            ST_WAIT: begin
                if (healthy_mism)      state_d = ST_REBOOT;
                else if (recfg_window) state_d = ST_RECFG;
            end
            ST_RECFG: begin
                if (healthy_mism)    state_d = ST_REBOOT;
                else if (recfg_done) state_d = ST_RESYNC;
                else if (expired)    state_d = ST_REBOOT;
            end
            ST_RESYNC: begin
                if (healthy_mism)     state_d = ST_REBOOT;
                else if (resync_done) state_d = ST_FULL;
                else if (expired)     state_d = ST_REBOOT;
            end
            ST_REBOOT: state_d = ST_REBOOT;
            default:   state_d = ST_REBOOT;
        endcase
    end

    AST_REBOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REBOOT) |=> (state_q == ST_REBOOT)); // R4

    AST_FAULTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && !healthy_mism) |=> (state_q != ST_REBOOT)); // R5

    AST_WINDOW_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && recfg_window && !healthy_mism) |=> (state_q == ST_RECFG)); // R6

endmodule

// File: rtl/lps_out_dec.sv
module lps_out_dec
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lps_state_e state_q,
    input  lps_state_e state_d,
    input  logic       bad_b_q,
    input  logic       mism_a,
    input  logic       mism_b,
    output logic       halt_a,
    output logic       halt_b,
    output logic       out_sel_b,
    output logic       recfg_req,
    output logic       resync_req,
    output logic       reboot_req
);

    always_comb begin
        halt_a    = 1'b0;
        halt_b    = 1'b0;
        out_sel_b = 1'b0;
        unique case (state_q)
            ST_FULL: begin
                halt_a    = mism_a;
                halt_b    = mism_b;
                out_sel_b = mism_a && !mism_b;
            end
            ST_RUN_A, ST_RUN_B, ST_WAIT, ST_RECFG, ST_RESYNC: begin
                halt_a    = !bad_b_q;
                halt_b    = bad_b_q;
                out_sel_b = !bad_b_q;
            end
            ST_REBOOT: begin
                halt_a = 1'b1;
                halt_b = 1'b1;
            end
            default: begin
                halt_a = 1'b1;
                halt_b = 1'b1;
            end
        endcase
    end

    assign recfg_req  = (state_q == ST_WAIT)   && (state_d == ST_RECFG);
    assign resync_req = (state_q == ST_RECFG)  && (state_d == ST_RESYNC);
    assign reboot_req = (state_q != ST_REBOOT) && (state_d == ST_REBOOT);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({recfg_req, resync_req, reboot_req})); // R11

    AST_A_HALTED_B_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_a && !halt_b) |-> out_sel_b); // R3

    AST_B_HALTED_A_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_b && !halt_a) |-> !out_sel_b); // R3

endmodule

// File: rtl/lockstep_pair_supervisor.sv
module lockstep_pair_supervisor
    import lps_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mism_a,
    input  logic             mism_b,
    input  logic             recfg_window,
    input  logic             recfg_done,
    input  logic             resync_done,
    input  logic [TMO_W-1:0] hs_timeout,
    output logic             halt_a,
    output logic             halt_b,
    output logic             out_sel_b,
    output logic             recfg_req,
    output logic             resync_req,
    output logic             reboot_req
);

    lps_state_e state_q;
    lps_state_e state_d;
    logic       bad_b_q;
    logic       expired;
    logic       hs_run;
    logic       hs_restart;

    assign hs_run     = (state_q == ST_RECFG) || (state_q == ST_RESYNC);
    assign hs_restart = (state_d != state_q);

    lps_hs_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hs_run),
        .restart (hs_restart),
        .limit   (hs_timeout),
        .expired (expired)
    );

    lps_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mism_a       (mism_a),
        .mism_b       (mism_b),
        .recfg_window (recfg_window),
        .recfg_done   (recfg_done),
        .resync_done  (resync_done),
        .expired      (expired),
        .state_q      (state_q),
        .state_d      (state_d),
        .bad_b_q      (bad_b_q)
    );

    lps_out_dec u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .state_d    (state_d),
        .bad_b_q    (bad_b_q),
        .mism_a     (mism_a),
        .mism_b     (mism_b),
        .halt_a     (halt_a),
        .halt_b     (halt_b),
        .out_sel_b  (out_sel_b),
        .recfg_req  (recfg_req),
        .resync_req (resync_req),
        .reboot_req (reboot_req)
    );

    AST_REBOOT_HALTS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> (halt_a && halt_b && !out_sel_b)); // R4

    AST_RESYNC_STROBE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |=> !resync_req); // R11

endmodule

// File: tb/lockstep_pair_supervisor_bench.sv
`timescale 1ns/1ps
module lockstep_pair_supervisor_bench;

    localparam int TMO_W = 8;
    localparam int LIM   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mism_a = 1'b0, mism_b = 1'b0;
    logic recfg_window = 1'b0, recfg_done = 1'b0, resync_done = 1'b0;
    logic [TMO_W-1:0] hs_timeout = TMO_W'(LIM);
    logic halt_a, halt_b, out_sel_b, recfg_req, resync_req, reboot_req;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #10 clk = ~clk;

    lockstep_pair_supervisor #(.TMO_W(TMO_W)) u_lockstep_pair_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .mism_a       (mism_a),
        .mism_b       (mism_b),
        .recfg_window (recfg_window),
        .recfg_done   (recfg_done),
        .resync_done  (resync_done),
        .hs_timeout   (hs_timeout),
        .halt_a       (halt_a),
        .halt_b       (halt_b),
        .out_sel_b    (out_sel_b),
        .recfg_req    (recfg_req),
        .resync_req   (resync_req),
        .reboot_req   (reboot_req)
    );

    // expected bits: {halt_a, halt_b, out_sel_b, recfg_req, resync_req, reboot_req}
    task automatic step(input logic ma, input logic mb, input logic w,
                        input logic cd, input logic sd,
                        input logic [5:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        mism_a = ma; mism_b = mb; recfg_window = w;
        recfg_done = cd; resync_done = sd;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mism_a = 0; mism_b = 0; recfg_window = 0; recfg_done = 0; resync_done = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                logic [5:0] got;
                it  = exp_q.pop_front();
                got = {halt_a, halt_b, out_sel_b, recfg_req, resync_req, reboot_req};
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got ha/hb/sel/cfg/sync/rb=%b expected %b", it.tag, got, it.exp);
                end
            end
        end
    end

    initial begin
        #4000000;
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state, R2 idle lockstep ignores window/done
        step(0,0,0,0,0, 6'b000000, "R1");
        step(0,0,1,1,1, 6'b000000, "R2");
        step(0,0,0,1,0, 6'b000000, "R7 done ignored in lockstep");

        // B faults, full recovery
        step(0,1,0,0,0, 6'b010000, "R3 B fault same cycle");
        step(0,1,1,0,0, 6'b010000, "R6 no req in degraded cycle / R5");
        step(0,1,0,0,0, 6'b010000, "R6 wait without window");
        step(0,0,1,0,0, 6'b010100, "R6 req on window");
        step(0,1,0,0,1, 6'b010000, "R7 reconfig waiting / R5");
        step(0,0,0,1,0, 6'b010010, "R7 resync req");
        step(0,0,0,1,0, 6'b010000, "R7 done ignored in resync");
        step(0,0,0,0,1, 6'b010000, "R8 resync done cycle");
        step(0,0,0,0,0, 6'b000000, "R8 back to lockstep");

        // A faults, resync times out
        step(1,0,0,0,0, 6'b101000, "R3 A fault same cycle");
        step(1,0,0,0,0, 6'b101000, "R5 A flag ignored");
        step(0,0,1,0,0, 6'b101100, "R6 req on first window");
        step(0,0,0,1,0, 6'b101010, "R10 done at first cycle");
        step(0,0,0,0,0, 6'b101000, "R10 resync cnt0");
        step(0,0,0,0,0, 6'b101000, "R10 resync cnt1");
        step(0,0,0,0,0, 6'b101000, "R10 resync cnt2");
        step(0,0,0,0,0, 6'b101001, "R10 resync timeout");
        step(0,0,0,0,1, 6'b110000, "R4 reboot holds");
        step(1,0,1,1,0, 6'b110000, "R4 reboot sticky");

        // B faults, reconfig done exactly at the limit
        do_reset();
        step(0,0,0,0,0, 6'b000000, "R1 after second reset");
        step(0,1,0,0,0, 6'b010000, "R3");
        step(0,0,0,0,0, 6'b010000, "R3 degraded");
        step(0,0,1,0,0, 6'b010100, "R6");
        step(0,0,0,0,0, 6'b010000, "R10 recfg cnt0");
        step(0,0,0,0,0, 6'b010000, "R10 recfg cnt1");
        step(0,0,0,0,0, 6'b010000, "R10 recfg cnt2");
        step(0,0,0,1,0, 6'b010010, "R10 done at limit accepted");
        step(0,0,0,0,1, 6'b010000, "R8");
        step(0,0,0,0,0, 6'b000000, "R8 lockstep");

        // healthy pair fails while waiting
        step(1,0,0,0,0, 6'b101000, "R3");
        step(0,0,0,0,0, 6'b101000, "R3 degraded");
        step(0,1,0,0,0, 6'b101001, "R9 healthy mismatch in wait");
        step(0,0,0,0,0, 6'b110000, "R4 reboot state");

        // both pairs disagree at once
        do_reset();
        step(1,1,0,0,0, 6'b110001, "R4 double mismatch");
        step(0,0,0,0,0, 6'b110000, "R4 both halted");

        // reconfiguration handshake times out
        do_reset();
        step(0,1,0,0,0, 6'b010000, "R3");
        step(1,0,0,0,0, 6'b010001, "R9 healthy mismatch in degraded");
        do_reset();
        step(0,1,0,0,0, 6'b010000, "R3");
        step(0,0,0,0,0, 6'b010000, "R3 degraded");
        step(0,0,1,0,0, 6'b010100, "R6");
        step(0,0,0,0,0, 6'b010000, "R10 cnt0");
        step(0,0,0,0,0, 6'b010000, "R10 cnt1");
        step(0,0,0,0,0, 6'b010000, "R10 cnt2");
        step(0,0,0,0,0, 6'b010001, "R10 recfg timeout");
        step(0,0,0,0,0, 6'b110000, "R4 after timeout");

        @(negedge clk);
        #10;
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule